// File: doc/BRIEF.md
# SPI status-register write sequencer

This block is the status-register path of a serial flash slave that talks SPI mode 0. All four pins (serial clock, active-low select, data in and the active-low write-protect pin) pass through a synchronizer into the system clock domain. Edges of the serial clock and of the select line are detected there. Incoming bits are shifted in on rising serial-clock edges. When the select line rises, the first byte is decoded as a command: set-write-enable (0x06), write-status (0x01) or read-status (0x05).

A write-status command carries one data byte, sent most significant bit first. The block takes it only if four things hold: the frame was exactly sixteen bits long, write-enable was set by an earlier command, no write cycle is running, and the hardware lock is off. When it is taken, a timed write cycle runs. During that cycle the busy bit reads 1. At its end the new protection fields are committed and write-enable is cleared. The read-status command shifts the status byte out on the data-out pin on falling serial-clock edges. It repeats the byte for as long as select stays low, so software can poll the busy bit during a write cycle.

Status byte layout: bit 0 busy, bit 1 write-enable, bits 2 to 5 the four protect-level bits, bit 6 always 0, bit 7 the lock-enable bit.

Top module: `spi_sr_writer`

## Requirements
- R1: After reset the status byte is 0x00, the busy output is 0 and the data-out pin is 0.
- R2: A frame that carries exactly eight bits with the value 0x06 sets the write-enable bit (status bit 1) when the select line rises.
- R3: A frame of exactly sixteen bits, opcode 0x01 followed by a data byte sent MSB first, starts a write cycle when select rises. It needs write-enable set, no cycle running and the hardware lock off. The busy output and status bit 0 go to 1.
- R4: A command frame whose length is not exactly its own bit count is discarded with no change to status or busy. That count is 8 bits for 0x06 and 16 bits for 0x01.
- R5: A write-status frame received while write-enable is 0 starts no cycle and leaves the status byte unchanged.
- R6: Busy stays 1 for exactly WRITE_CYCLES system clock cycles, with write-enable held at 1. The new fields appear on the same cycle busy falls, and write-enable is cleared on that cycle.
- R7: The committed value takes data bits 2 to 5 into status bits 2 to 5 and data bit 7 into status bit 7. Data bits 0, 1 and 6 have no effect, and status bit 6 stays 0.
- R8: While status bit 7 is 1 and the write-protect pin is low, write-status frames are ignored and the status is unchanged. With the pin high the same frame is accepted.
- R9: After opcode 0x05, each falling serial-clock edge drives the next status bit onto data-out, MSB first. The byte repeats while select stays low, and the live value is reported during a write cycle.
- R10: A write-status frame that arrives while a cycle is running is dropped. It neither changes the value being written nor starts a second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host (mode 0) |
| spi_cs_n | input | 1 | Active-low select; its rising edge ends a frame |
| spi_di | input | 1 | Serial data from the host |
| spi_wp_n | input | 1 | Active-low write-protect pin |
| spi_do | output | 1 | Serial status data to the host; 0 when not reading |
| status_o | output | 8 | Current status byte |
| busy_o | output | 1 | High while a write cycle runs |

## Verification
A wrong bit count or a bad opcode register shows up within a few system clocks of the select rising. Either a busy pulse appears that should not, or write-enable fails to appear on the status port. A broken cycle timer is only visible at the end of the cycle, as a busy pulse of the wrong length or fields committed early or late. The scenarios therefore sample busy just before and just after the nominal end. A fault in the output index or in the opcode latch is caught by reading status twice in one frame, both during a cycle and after it.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
   localparam int          BYTE_W   = 8;
   localparam logic [7:0]  OPC_WREN = 8'h06;
   localparam logic [7:0]  OPC_WRSR = 8'h01;
   localparam logic [7:0]  OPC_RDSR = 8'h05;

   // Writable part of the status byte
   typedef struct packed {
      logic       lock;      // status bit 7
      logic [3:0] prot;      // status bits 5..2
   } sr_cfg_t;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_WREN,
      CMD_WRSR
   } cmd_ev_t;
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
   parameter int              STAGES = 2,
   parameter int              WIDTH  = 4,
   parameter logic [WIDTH-1:0] IDLE  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int PIPE_W = STAGES * WIDTH;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sr_sync: STAGES must be at least 2");
   end

   logic [PIPE_W-1:0] pipe;

   if (STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= {2{IDLE}};
         else        pipe <= {pipe[WIDTH-1:0], async_i};
      end
   end else begin : g_deep
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= {STAGES{IDLE}};
         else        pipe <= {pipe[PIPE_W-WIDTH-1:0], async_i};
      end
   end

   assign sync_o = pipe[PIPE_W-1 -: WIDTH];
endmodule

// File: rtl/spi_sr_frame.sv
module spi_sr_frame
   import spi_sr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel_low,
   input  logic        sel_fall,
   input  logic        sel_rise,
   input  logic        sck_rise,
   input  logic        sck_fall,
   input  logic        di_s,
   input  logic [7:0]  status_i,
   output cmd_ev_t     cmd_o,
   output sr_cfg_t     wr_val_o,
   output logic        do_o
);
   localparam int FRAME_BITS = 2 * BYTE_W;
   localparam int CNT_SAT    = FRAME_BITS + 1;
   localparam int CNT_W      = $clog2(CNT_SAT + 1);

   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       shreg;
   logic [7:0]       opcode_q;
   logic [2:0]       out_idx;
   logic             do_q;
   logic             rd_active;

   assign rd_active = sel_low && (bit_cnt >= CNT_W'(BYTE_W)) && (opcode_q == OPC_RDSR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         opcode_q <= '0;
      end else if (sel_fall) begin
         bit_cnt  <= '0;
         opcode_q <= '0;
      end else if (sel_low && sck_rise) begin
         shreg <= {shreg[6:0], di_s};
         if (bit_cnt != CNT_W'(CNT_SAT))
            bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == CNT_W'(BYTE_W - 1))
            opcode_q <= {shreg[6:0], di_s};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_idx <= '0;
         do_q    <= 1'b0;
      end else if (!sel_low) begin
         out_idx <= '0;
         do_q    <= 1'b0;
      end else if (sck_fall && rd_active) begin
         do_q    <= status_i[3'd7 - out_idx];
         out_idx <= out_idx + 1'b1;
      end
   end

   always_comb begin
      cmd_o = CMD_NONE;
      if (sel_rise) begin
         if (bit_cnt == CNT_W'(BYTE_W) && opcode_q == OPC_WREN)
            cmd_o = CMD_WREN;
         else if (bit_cnt == CNT_W'(FRAME_BITS) && opcode_q == OPC_WRSR)
            cmd_o = CMD_WRSR;
      end
   end

   assign wr_val_o = '{lock: shreg[7], prot: shreg[5:2]};
   assign do_o     = do_q;
endmodule

// File: rtl/spi_sr_core.sv
module spi_sr_core
   import spi_sr_pkg::*;
#(
   parameter int WRITE_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  cmd_ev_t    cmd_i,
   input  sr_cfg_t    wr_val_i,
   input  logic       wp_n_s,
   output logic [7:0] status_o,
   output logic       busy_o
);
   localparam int TMR_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

   if (WRITE_CYCLES < 1) begin : g_bad_cycles
      $error("spi_sr_core: WRITE_CYCLES must be at least 1");
   end

   sr_cfg_t          cfg_q;
   sr_cfg_t          cfg_pend;
   logic             wel_q;
   logic             busy_q;
   logic [TMR_W-1:0] tmr;
   logic             hw_locked;

   assign hw_locked = cfg_q.lock && !wp_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         cfg_pend <= '0;
         wel_q    <= 1'b0;
         busy_q   <= 1'b0;
         tmr      <= '0;
      end else if (busy_q) begin
         if (tmr == '0) begin
            busy_q <= 1'b0;
            wel_q  <= 1'b0;
            cfg_q  <= cfg_pend;
         end else begin
            tmr <= tmr - 1'b1;
         end
      end else begin
         unique case (cmd_i)
            CMD_WREN: wel_q <= 1'b1;
            CMD_WRSR: begin
               if (wel_q && !hw_locked) begin
                  busy_q   <= 1'b1;
                  tmr      <= TMR_W'(WRITE_CYCLES - 1);
                  cfg_pend <= wr_val_i;
               end
            end
            default: ;
         endcase
      end
   end

   assign status_o = {cfg_q.lock, 1'b0, cfg_q.prot, wel_q, busy_q};
   assign busy_o   = busy_q;
endmodule

// File: rtl/spi_sr_writer.sv
module spi_sr_writer
   import spi_sr_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int WRITE_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_di,
   input  logic       spi_wp_n,
   output logic       spi_do,
   output logic [7:0] status_o,
   output logic       busy_o
);
   // pin bundle order: {wp_n, di, cs_n, sck}
   localparam logic [3:0] PIN_IDLE = 4'b1010;

   logic [3:0] pins_s;
   logic       sck_d, cs_d;
   logic       sck_rise, sck_fall, cs_rise, cs_fall;
   cmd_ev_t    cmd;
   sr_cfg_t    wr_val;

   spi_sr_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (4),
      .IDLE   (PIN_IDLE)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({spi_wp_n, spi_di, spi_cs_n, spi_sck}),
      .sync_o  (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= pins_s[0];
         cs_d  <= pins_s[1];
      end
   end

   assign sck_rise =  pins_s[0] && !sck_d;
   assign sck_fall = !pins_s[0] &&  sck_d;
   assign cs_rise  =  pins_s[1] && !cs_d;
   assign cs_fall  = !pins_s[1] &&  cs_d;

   spi_sr_frame u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_low  (!pins_s[1]),
      .sel_fall (cs_fall),
      .sel_rise (cs_rise),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .di_s     (pins_s[2]),
      .status_i (status_o),
      .cmd_o    (cmd),
      .wr_val_o (wr_val),
      .do_o     (spi_do)
   );

   spi_sr_core #(
      .WRITE_CYCLES (WRITE_CYCLES)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_i    (cmd),
      .wr_val_i (wr_val),
      .wp_n_s   (pins_s[3]),
      .status_o (status_o),
      .busy_o   (busy_o)
   );
endmodule

// File: rtl/spi_sr_writer_chk.sv
module spi_sr_writer_chk #(
   parameter int WRITE_CYCLES = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic [7:1] sr_hi,
   input logic       busy_o
);
   int unsigned run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_cnt <= 0;
      else if (busy_o) run_cnt <= run_cnt + 1;
      else             run_cnt <= 0;
   end

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> run_cnt == WRITE_CYCLES);

   // R6
   wel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> sr_hi[1]);

   // R6
   wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !sr_hi[1]);

   // R5
   start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(sr_hi[1]));

   // R7
   cfg_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy_o) |-> $stable(sr_hi[7:2]));
endmodule

bind spi_sr_writer spi_sr_writer_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .sr_hi  (status_o[7:1]),
   .busy_o (busy_o)
);

// File: tb/spi_sr_writer_bench.sv
module spi_sr_writer_bench;
   localparam int W = 1200;   // write-cycle length used by the bench
   localparam int H = 8;      // system clocks per serial half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b1, di = 1'b0, wp_n = 1'b1;
   logic       do_w;
   logic [7:0] st;
   logic       busy;

   int n_chk = 0, n_bad = 0, cyc = 0, rise_cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spi_sr_writer #(.SYNC_STAGES(2), .WRITE_CYCLES(W)) u_spi_sr_writer (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_di(di),
      .spi_wp_n(wp_n), .spi_do(do_w), .status_o(st), .busy_o(busy));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) tick(1);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic spi_frame(input logic [31:0] bits, input int nbits);
      cs_n = 1'b0;
      tick(H);
      for (int i = nbits - 1; i >= 0; i--) begin
         di = bits[i];
         tick(H); sck = 1'b1;
         tick(H); sck = 1'b0;
      end
      tick(H);
      cs_n = 1'b1;
      rise_cyc = cyc;
      tick(2 * H);
   endtask

   task automatic spi_rdsr(output logic [7:0] b0, output logic [7:0] b1);
      logic [15:0] got;
      logic [7:0]  opc;
      opc = 8'h05;
      cs_n = 1'b0;
      tick(H);
      for (int i = 7; i >= 0; i--) begin
         di = opc[i];
         tick(H); sck = 1'b1;
         tick(H); sck = 1'b0;
      end
      for (int i = 15; i >= 0; i--) begin
         di = 1'b0;
         tick(H); got[i] = do_w; sck = 1'b1;
         tick(H); sck = 1'b0;
      end
      tick(H);
      cs_n = 1'b1;
      tick(2 * H);
      b0 = got[15:8];
      b1 = got[7:0];
   endtask

   task automatic wren();
      spi_frame(32'h06, 8);
   endtask

   task automatic t_reset();
      check("R1 status", st, 8'h00);
      check("R1 busy", {7'd0, busy}, 8'h00);
      check("R1 do", {7'd0, do_w}, 8'h00);
   endtask

   task automatic t_no_wel();
      spi_frame({16'd0, 8'h01, 8'hFF}, 16);
      check("R5 busy", {7'd0, busy}, 8'h00);
      check("R5 status", st, 8'h00);
   endtask

   task automatic t_wren_len();
      spi_frame(32'h03, 7);
      check("R4 wren 7 bits", st, 8'h00);
      spi_frame({23'd0, 8'h06, 1'b0}, 9);
      check("R4 wren 9 bits", st, 8'h00);
      wren();
      check("R2 wren", st, 8'h02);
   endtask

   task automatic t_wrsr_len();
      spi_frame({17'd0, 8'h01, 7'h7F}, 15);
      check("R4 wrsr 15 bits busy", {7'd0, busy}, 8'h00);
      check("R4 wrsr 15 bits status", st, 8'h02);
      spi_frame({15'd0, 8'h01, 8'hFF, 1'b0}, 17);
      check("R4 wrsr 17 bits busy", {7'd0, busy}, 8'h00);
      check("R4 wrsr 17 bits status", st, 8'h02);
   endtask

   task automatic t_cycle();
      logic [7:0] b0, b1;
      int start;
      spi_frame({16'd0, 8'h01, 8'hFF}, 16);
      start = rise_cyc;
      check("R3 busy start", {7'd0, busy}, 8'h01);
      check("R6 status during cycle", st, 8'h03);
      spi_rdsr(b0, b1);
      check("R9 read during cycle byte0", b0, 8'h03);
      check("R9 read during cycle byte1", b1, 8'h03);
      spi_frame({16'd0, 8'h01, 8'h00}, 16);   // R10: arrives mid-cycle
      wait_to(start + W - 2);
      check("R6 busy before end", {7'd0, busy}, 8'h01);
      wait_to(start + W + 10);
      check("R6 busy after end", {7'd0, busy}, 8'h00);
      check("R7 R10 committed value", st, 8'hBC);
      tick(4 * H);
      check("R10 no second cycle", {7'd0, busy}, 8'h00);
   endtask

   task automatic t_hw_lock();
      int start;
      wp_n = 1'b0;
      tick(H);
      wren();
      check("R2 wren while locked", st, 8'hBE);
      spi_frame({16'd0, 8'h01, 8'h00}, 16);
      check("R8 locked busy", {7'd0, busy}, 8'h00);
      tick(2 * H);
      check("R8 locked status", st, 8'hBE);
      wp_n = 1'b1;
      tick(H);
      spi_frame({16'd0, 8'h01, 8'h00}, 16);
      start = rise_cyc;
      check("R8 unlocked busy", {7'd0, busy}, 8'h01);
      wait_to(start + W + 10);
      check("R8 unlocked status", st, 8'h00);
   endtask

   task automatic t_fields();
      logic [7:0] b0, b1;
      int start;
      wren();
      spi_frame({16'd0, 8'h01, 8'h43}, 16);
      start = rise_cyc;
      wait_to(start + W + 10);
      check("R7 masked bits", st, 8'h00);
      wren();
      spi_frame({16'd0, 8'h01, 8'h94}, 16);
      start = rise_cyc;
      wait_to(start + W + 10);
      check("R7 field map", st, 8'h94);
      spi_rdsr(b0, b1);
      check("R9 read byte0", b0, 8'h94);
      check("R9 read byte1", b1, 8'h94);
      check("R1 do idle after read", {7'd0, do_w}, 8'h00);
   endtask

   always @(posedge clk) begin
      if (!done && cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual cycle %0d expected below 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_no_wel();
      t_wren_len();
      t_wrsr_len();
      t_cycle();
      t_hw_lock();
      t_fields();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule